// File: doc/BRIEF.md
# Sample-Rate Multi-Waveform Oscillator

This block is the tone source of one synthesizer voice. A 24-bit phase accumulator advances by a frequency-dependent increment once per sample strobe. Four waveform shapes are derived from it: pulse, sawtooth, triangle and a pseudo-random noise pattern. A 23-bit shift register steps whenever accumulator bit 19 rises, and it supplies the noise shape. A control byte chooses which shapes are active. When several shapes are active, they are merged by a bitwise AND into one 12-bit unsigned word. When no shape is active, the output rests at midscale.

The sample strobe is a plain control pin. It has no ready signal, and the block accepts every strobe, so there is no back-pressure at any edge. The output word is registered. It changes only on a clock edge where the strobe is high, and it then reflects the updated phase and noise state. Control bits 0 to 3 (gate, sync, ring modulation, test) are present on the port but have no effect on this block. Converting the word to an analog or floating-point sample is left to a downstream stage.

Top module: `osc_voice`

## Requirements
- R1: While reset is low, and at the first edge after reset is released, `wave_out` is 0x800. The accumulator is zero and the noise register holds 0x7FFFF8.
- R2: On each edge with `sample_en` high, the accumulator gains floor(floor(freq_word*32768/44100)*256) modulo 2^24. Without the strobe, it keeps its value.
- R3: `wave_out` changes only on an edge with `sample_en` high. It then shows the shapes computed from the post-update accumulator, the post-update noise register and the `ctrl`/`pulse_width` present at that edge.
- R4: If `ctrl` bits 7:4 are all zero, a strobe sets `wave_out` to 0x800.
- R5: If any of `ctrl` bit 4 (triangle), bit 5 (sawtooth), bit 6 (pulse) or bit 7 (noise) is set, `wave_out` is 0xFFF ANDed with every selected shape.
- R6: The pulse shape is 0xFFF when accumulator bits 23:16 are less than `pulse_width`, otherwise 0x000. A width of 0 therefore always gives 0x000.
- R7: The sawtooth shape equals accumulator bits 23:12.
- R8: The triangle shape is accumulator bits 22:12 placed in bits 11:1 with bit 0 zero. That value is XORed with 0xFFE when accumulator bit 23 is set.
- R9: The noise register shifts left by one only when accumulator bit 19 goes from 0 to 1 in an update. The new bit 0 is old bit 22 XOR old bit 17.
- R10: The noise shape takes bits 11 to 4 from register bits 22, 20, 16, 13, 11, 7, 4, 2 respectively. Its bits 3:0 are zero.
- R11: `ctrl` bits 3:0 have no effect on `wave_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | One-cycle sample strobe; advances phase and noise |
| freq_word | input | 16 | Pitch word used to derive the phase increment |
| pulse_width | input | 8 | Threshold compared with the top accumulator byte |
| ctrl | input | 8 | Shape select in bits 7:4; bits 3:0 ignored |
| wave_out | output | 12 | Registered unsigned waveform word |

## Verification
The assertions assume that `ctrl` and `pulse_width` are stable around the strobe edge. They also assume that reset is held for at least one clock before `sample_en` is used. The stimulus changes inputs only at falling edges and asserts reset for several cycles before any strobe. The stimulus mixes strobe and idle cycles, so the hold property and the single-shape properties are all triggered. It sweeps widths 0, mid and 0xFF. It uses the maximum frequency word so that bit 19 rises often and the noise register steps many times.

// File: rtl/osc_voice_pkg.sv
package osc_voice_pkg;
  // Control byte shape-select positions
  localparam int CTRL_TRI_BIT   = 4;
  localparam int CTRL_SAW_BIT   = 5;
  localparam int CTRL_PULSE_BIT = 6;
  localparam int CTRL_NOISE_BIT = 7;

  // Noise register bits feeding the output, most significant output bit first
  localparam int NOISE_TAP_N = 8;
  localparam int NOISE_TAPS [NOISE_TAP_N] = '{22, 20, 16, 13, 11, 7, 4, 2};

  typedef struct packed {
    logic noise_on;
    logic pulse_on;
    logic saw_on;
    logic tri_on;
  } wave_sel_t;

  function automatic wave_sel_t decode_sel(input logic [3:0] hi_nibble);
    wave_sel_t s;
    s.tri_on   = hi_nibble[CTRL_TRI_BIT - 4];
    s.saw_on   = hi_nibble[CTRL_SAW_BIT - 4];
    s.pulse_on = hi_nibble[CTRL_PULSE_BIT - 4];
    s.noise_on = hi_nibble[CTRL_NOISE_BIT - 4];
    return s;
  endfunction
endpackage

// File: rtl/osc_phase_acc.sv
module osc_phase_acc #(
  parameter int FREQ_W        = 16,
  parameter int ACC_W         = 24,
  parameter int WAVE_W        = 12,
  parameter int SAMPLE_RATE   = 44100,
  parameter int NOISE_CLK_BIT = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [FREQ_W-1:0] freq,
  output logic [WAVE_W-1:0] phase_hi,
  output logic              noise_tick
);
  localparam int PROD_W = FREQ_W + 15;

  logic [PROD_W-1:0] scaled;
  logic [PROD_W-1:0] quot;
  logic [ACC_W-1:0]  inc;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_d;

  // Increment = (freq * 2^15 / rate) * 2^8, truncated to accumulator width
  assign scaled = {freq, 15'd0};
  assign quot   = scaled / PROD_W'(SAMPLE_RATE);
  assign inc    = ACC_W'({quot, 8'd0});
  assign acc_d  = acc_q + inc;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= acc_d;
  end

  // Shapes are built from the post-update phase
  assign phase_hi   = acc_d[ACC_W-1 -: WAVE_W];
  assign noise_tick = step & ~acc_q[NOISE_CLK_BIT] & acc_d[NOISE_CLK_BIT];
endmodule

// File: rtl/osc_noise_lfsr.sv
module osc_noise_lfsr
  import osc_voice_pkg::*;
#(
  parameter int             LEN    = 23,
  parameter int             TAP_HI = 22,
  parameter int             TAP_LO = 17,
  parameter logic [LEN-1:0] SEED   = 23'h7FFFF8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  output logic [NOISE_TAP_N-1:0] taps_next
);
  logic [LEN-1:0] state_q;
  logic [LEN-1:0] state_d;
  logic [LEN-1:0] shifted;

  assign shifted = {state_q[LEN-2:0], state_q[TAP_HI] ^ state_q[TAP_LO]};
  assign state_d = tick ? shifted : state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  for (genvar k = 0; k < NOISE_TAP_N; k++) begin : g_tap
    assign taps_next[NOISE_TAP_N-1-k] = state_d[NOISE_TAPS[k]];
  end
endmodule

// File: rtl/osc_wave_mix.sv
module osc_wave_mix
  import osc_voice_pkg::*;
#(
  parameter int WAVE_W = 12,
  parameter int PW_W   = 8
) (
  input  wave_sel_t              sel,
  input  logic [WAVE_W-1:0]      phase_hi,
  input  logic [PW_W-1:0]        pulse_width,
  input  logic [NOISE_TAP_N-1:0] noise_taps,
  output logic [WAVE_W-1:0]      wave
);
  localparam logic [WAVE_W-1:0] ALL_ONES = '1;
  localparam logic [WAVE_W-1:0] MIDSCALE = {1'b1, {(WAVE_W-1){1'b0}}};
  localparam logic [WAVE_W-1:0] TRI_MASK = {{(WAVE_W-1){1'b1}}, 1'b0};

  logic [WAVE_W-1:0] pulse_w, saw_w, tri_w, noise_w, tri_raw;

  assign pulse_w = (phase_hi[WAVE_W-1 -: PW_W] < pulse_width) ? ALL_ONES : '0;
  assign saw_w   = phase_hi;
  assign tri_raw = {phase_hi[WAVE_W-2:0], 1'b0};
  assign tri_w   = phase_hi[WAVE_W-1] ? (tri_raw ^ TRI_MASK) : tri_raw;
  assign noise_w = {noise_taps, {(WAVE_W-NOISE_TAP_N){1'b0}}};

  always_comb begin
    if (sel == '0) begin
      wave = MIDSCALE;
    end else begin
      wave = ALL_ONES;
      if (sel.pulse_on) wave = wave & pulse_w;
      if (sel.saw_on)   wave = wave & saw_w;
      if (sel.tri_on)   wave = wave & tri_w;
      if (sel.noise_on) wave = wave & noise_w;
    end
  end
endmodule

// File: rtl/osc_voice.sv
module osc_voice
  import osc_voice_pkg::*;
#(
  parameter int FREQ_W      = 16,
  parameter int ACC_W       = 24,
  parameter int WAVE_W      = 12,
  parameter int PW_W        = 8,
  parameter int SAMPLE_RATE = 44100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [FREQ_W-1:0] freq_word,
  input  logic [PW_W-1:0]   pulse_width,
  input  logic [7:0]        ctrl,
  output logic [WAVE_W-1:0] wave_out
);
  localparam logic [WAVE_W-1:0] MIDSCALE = {1'b1, {(WAVE_W-1){1'b0}}};

  wave_sel_t              sel;
  logic [WAVE_W-1:0]      phase_hi;
  logic                   noise_tick;
  logic [NOISE_TAP_N-1:0] noise_taps;
  logic [WAVE_W-1:0]      wave_d;
  logic                   ctrl_lo_unused;

  // Gate, sync, ring modulation and test bits are accepted but inert here
  assign ctrl_lo_unused = ^ctrl[3:0];
  assign sel            = decode_sel(ctrl[7:4]);

  osc_phase_acc #(
    .FREQ_W(FREQ_W), .ACC_W(ACC_W), .WAVE_W(WAVE_W),
    .SAMPLE_RATE(SAMPLE_RATE), .NOISE_CLK_BIT(19)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .step(sample_en), .freq(freq_word),
    .phase_hi(phase_hi), .noise_tick(noise_tick)
  );

  osc_noise_lfsr #(
    .LEN(23), .TAP_HI(22), .TAP_LO(17), .SEED(23'h7FFFF8)
  ) u_noise (
    .clk(clk), .rst_n(rst_n), .tick(noise_tick), .taps_next(noise_taps)
  );

  osc_wave_mix #(
    .WAVE_W(WAVE_W), .PW_W(PW_W)
  ) u_mix (
    .sel(sel), .phase_hi(phase_hi), .pulse_width(pulse_width),
    .noise_taps(noise_taps), .wave(wave_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         wave_out <= MIDSCALE;
    else if (sample_en) wave_out <= wave_d;
  end
endmodule

// File: rtl/osc_voice_chk.sv
module osc_voice_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sample_en,
  input logic [7:0]  pulse_width,
  input logic [7:0]  ctrl,
  input logic [11:0] wave_out
);
  assert_reset_mid_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> wave_out == 12'h800);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(wave_out));

  assert_midscale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && ctrl[7:4] == 4'b0000) |=> wave_out == 12'h800);

  assert_pulse_rails_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && ctrl[7:4] == 4'b0100) |=> (wave_out == 12'h000 || wave_out == 12'hFFF));

  assert_pulse_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && ctrl[6] && pulse_width == 8'd0) |=> wave_out == 12'h000);

  assert_tri_lsb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && ctrl[4]) |=> !wave_out[0]);

  assert_noise_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && ctrl[7]) |=> wave_out[3:0] == 4'h0);
endmodule

bind osc_voice osc_voice_chk u_osc_voice_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
  .pulse_width(pulse_width), .ctrl(ctrl), .wave_out(wave_out)
);

// File: tb/test_osc_voice.sv
module test_osc_voice;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0;
  logic [15:0] freq_word = '0;
  logic [7:0]  pulse_width = '0;
  logic [7:0]  ctrl = '0;
  logic [11:0] wave_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference model state
  int m_acc = 0;
  int m_nr  = 'h7FFFF8;
  int m_out = 'h800;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_voice i_osc_voice (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .freq_word(freq_word),
    .pulse_width(pulse_width), .ctrl(ctrl), .wave_out(wave_out)
  );

  function automatic int model_wave(int a, int n, int pw, int c);
    int w;
    int t;
    int taps[$] = '{22, 20, 16, 13, 11, 7, 4, 2};
    if ((c & 'hF0) == 0) return 'h800;
    w = 'hFFF;
    if (c & 'h40) w &= (((a >> 16) & 'hFF) < pw) ? 'hFFF : 0;
    if (c & 'h20) w &= (a >> 12) & 'hFFF;
    if (c & 'h10) begin
      t = (a >> 11) & 'hFFE;
      if (a & 'h800000) t ^= 'hFFE;
      w &= t;
    end
    if (c & 'h80) begin
      t = 0;
      foreach (taps[k]) t |= ((n >> taps[k]) & 1) << (11 - k);
      w &= t;
    end
    return w;
  endfunction

  task automatic model_update(int f, int pw, int c);
    int old_acc;
    int inc;
    old_acc = m_acc;
    inc = ((f * 32768) / 44100) * 256;
    m_acc = (m_acc + inc) & 'hFFFFFF;
    if (((old_acc >> 19) & 1) == 0 && ((m_acc >> 19) & 1) == 1)
      m_nr = ((m_nr << 1) | (((m_nr >> 22) ^ (m_nr >> 17)) & 1)) & 'h7FFFFF;
    m_out = model_wave(m_acc, m_nr, pw, c);
  endtask

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: wave_out=%03h expected %03h", req, actual, expected);
    end
  endtask

  // Called at a falling edge; compares at the next falling edge
  task automatic step(bit en, int f, int pw, int c, string req);
    sample_en   = en;
    freq_word   = 16'(f);
    pulse_width = 8'(pw);
    ctrl        = 8'(c);
    @(posedge clk);
    if (en) model_update(f, pw, c);
    @(negedge clk);
    check(req, int'(wave_out), m_out);
  endtask

  task automatic run(int n, int f, int pw, int c, string req);
    for (int i = 0; i < n; i++) step(1'b1, f, pw, c, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", int'(wave_out), 'h800);
    rst_n = 1'b1;
    step(1'b0, 0, 0, 0, "R1 idle after reset");

    // R4 and R11: no shape selected, low control bits toggled
    run(10, 3000, 'h40, 'h00, "R4 midscale");
    run(10, 3000, 'h40, 'h0F, "R11 low bits with no shape");

    // R7 and R2: sawtooth over several frequencies
    run(60, 1000, 0, 'h20, "R7 saw low freq");
    run(60, 40000, 0, 'h20, "R2 saw high freq wrap");
    run(10, 0, 0, 'h20, "R2 zero increment");

    // R8: triangle across both halves
    run(200, 5000, 0, 'h10, "R8 triangle");

    // R6: pulse widths
    run(40, 7000, 0, 'h40, "R6 pulse width zero");
    run(80, 7000, 'h80, 'h40, "R6 pulse half");
    run(80, 7000, 'hFF, 'h40, "R6 pulse max width");

    // R9 and R10: noise with fast stepping
    run(600, 'hFFFF, 0, 'h80, "R9 R10 noise max freq");
    run(200, 9000, 0, 'h80, "R9 noise slower");

    // R5: combinations
    run(100, 6000, 'h60, 'h30, "R5 saw and triangle");
    run(100, 6000, 'h60, 'h60, "R5 saw and pulse");
    run(100, 'hFFFF, 'hA0, 'hF0, "R5 all four");

    // R11: same combinations with gate/sync/ring/test set
    run(100, 6000, 'h60, 'h3F, "R11 low bits with saw+tri");
    run(100, 'hFFFF, 'hA0, 'hF5, "R11 low bits with all shapes");

    // R3: idle cycles with changing inputs must hold the output
    for (int i = 0; i < 300; i++)
      step(1'(i % 3 == 0), 1000 + 97 * i, i & 'hFF, ((i * 37) & 'hF0) | (i & 'hF),
           "R3 strobe gating");

    // Mixed pseudo-random patterns
    for (int i = 0; i < 2000; i++)
      step(1'($urandom_range(0, 3) != 0), $urandom_range(0, 'hFFFF),
           $urandom_range(0, 'hFF), $urandom_range(0, 'hFF), "R5 R9 mixed stimulus");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule